// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write-and-Poll Controller

This block sits on the host side of a byte-wide, paged, electrically erasable memory with three active-low strobes: chip enable, output enable and write enable. After a single start pulse it writes from 1 to a full page of bytes to one page of the device. The bytes come from a local buffer, which the controller reads through an index/data pair. The unlock prefix of the protected mode can be sent first. The controller then finds the end of the device's internal programming cycle by reading the device repeatedly, so it does not have to wait out the worst-case write time.

Two completion tests are available, chosen per request. In the first, the last written address is read back until its most significant data bit matches the bit that was written. In the second, reads repeat until two reads in a row return the same bit 6. If neither test reports completion within a fixed number of reads, the operation ends with a timeout flag. Every strobe width, guard time and read width is a parameter counted in clock cycles. Elaboration checks reject values that would break the device's minimum timings or its byte-load window.

Top module: `nvm_page_writer`

## Requirements
- R1: While reset is held, and at any time no operation is in progress, chip enable, output enable and write enable are all high (inactive), the data bus is not driven, and `busy` and `done` are low.
- R2: When `unlock_req` is set at start, the first three write strobes carry data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, before any buffer byte. With `unlock_req` clear, no such writes occur.
- R3: For a request of N bytes (1 to 128), buffer entry i (0 to N-1) is written to address {page_sel, i[6:0]}, in ascending order of i. Exactly N such strobes are issued, and all of them share address bits 15 to 7.
- R4: Write enable stays low for at least WE_LOW_CYC cycles and high for at least WE_HIGH_CYC cycles between strobes. Address and write data are stable while it is low, and successive falling edges are less than the byte-load window apart.
- R5: Output enable is high whenever write enable is low. It has been high for at least OE_GUARD_CYC cycles at each write-enable fall, and write enable has been high for at least OE_GUARD_CYC cycles before output enable falls.
- R6: Each poll read holds output enable low, with chip enable low and the data bus released, for at least READ_CYC cycles before the sample is taken.
- R7: With `toggle_mode` clear, polling ends successfully at the first read whose bit 7 equals bit 7 of the last byte written.
- R8: With `toggle_mode` set, polling ends successfully at the first read whose bit 6 equals bit 6 of the read just before it.
- R9: If POLL_LIMIT reads pass without completion, the operation ends with `timed_out` high in the same cycle as `done`.
- R10: `start` is ignored while `busy` is high, when `byte_count` is 0, and when `byte_count` is above 128.
- R11: `busy` rises the cycle after an accepted start. `done` is a single-cycle pulse, after which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| unlock_req | input | 1 | Send the three-write unlock prefix first |
| toggle_mode | input | 1 | 1: bit-6 toggle polling, 0: bit-7 data polling |
| page_sel | input | ADDR_W-PAGE_BITS | Page number, upper address bits |
| byte_count | input | PAGE_BITS+1 | Number of bytes to write, 1 to 128 |
| buf_idx | output | PAGE_BITS | Index into the local byte buffer |
| buf_data | input | DATA_W | Buffer byte at `buf_idx`, same cycle |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Write data toward memory |
| mem_din | input | DATA_W | Read data from memory |
| mem_drive | output | 1 | Enables the host data driver |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | With `done`: polling limit reached |

## Verification
The hardest behaviour to reach from the ports is the end of polling. The bench therefore models the device's busy phase for a chosen number of reads per operation. During that phase the model returns an inverted bit 7 and a bit 6 that flips on each read, and afterwards it returns the true last byte. Choosing the busy length against the true bit 6 of the last byte decides whether toggle polling stops on the first ready read or the one after it. Choosing it beyond the poll limit drives both modes into timeout. A start pulse sent in the middle of a burst, with a different page number, shows that a running burst cannot be hijacked.

// File: rtl/nvm_pw_pkg.sv
package nvm_pw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SETUP,
      ST_WLOW,
      ST_WHIGH,
      ST_PGAP,
      ST_PREAD,
      ST_FIN
   } pw_state_e;

   localparam int UNLOCK_LEN = 3;

   // Unlock prefix: step 0 and 2 target 0x5555, step 1 targets 0x2AAA
   function automatic logic [15:0] unlock_addr(input logic [1:0] k);
      return (k == 2'd1) ? 16'h2AAA : 16'h5555;
   endfunction

   function automatic logic [7:0] unlock_data(input logic [1:0] k);
      case (k)
         2'd0:    return 8'hAA;
         2'd1:    return 8'h55;
         default: return 8'hA0;
      endcase
   endfunction

endpackage

// File: rtl/nvm_pw_timer.sv
module nvm_pw_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/nvm_pw_poll_eval.sv
module nvm_pw_poll_eval #(
   parameter int DATA_W = 8
) (
   input  logic              toggle_mode,
   input  logic [DATA_W-1:0] sample,
   input  logic              ref_msb,
   input  logic              prev_b6,
   input  logic              have_prev,
   output logic              ready
);
   logic unused_sample_bits;
   assign unused_sample_bits = ^sample[5:0];

   always_comb begin
      if (toggle_mode) ready = have_prev && (sample[6] == prev_b6);
      else             ready = (sample[7] == ref_msb);
   end
endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer
   import nvm_pw_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 8,
   parameter int PAGE_BITS      = 7,
   parameter int CLK_NS         = 10,
   parameter int WE_LOW_CYC     = 10,
   parameter int WE_HIGH_CYC    = 10,
   parameter int OE_GUARD_CYC   = 2,
   parameter int READ_CYC       = 16,
   parameter int POLL_LIMIT     = 1000,
   parameter int LOAD_WINDOW_NS = 100000,
   parameter bit HAS_UNLOCK     = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        unlock_req,
   input  logic                        toggle_mode,
   input  logic [ADDR_W-PAGE_BITS-1:0] page_sel,
   input  logic [PAGE_BITS:0]          byte_count,
   output logic [PAGE_BITS-1:0]        buf_idx,
   input  logic [DATA_W-1:0]           buf_data,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [DATA_W-1:0]           mem_dout,
   input  logic [DATA_W-1:0]           mem_din,
   output logic                        mem_drive,
   output logic                        mem_ce_n,
   output logic                        mem_oe_n,
   output logic                        mem_we_n,
   output logic                        busy,
   output logic                        done,
   output logic                        timed_out
);
   localparam int PG_W     = ADDR_W - PAGE_BITS;
   localparam int STEP_W   = PAGE_BITS + 2;
   localparam int BYTE_CYC = 1 + OE_GUARD_CYC + WE_LOW_CYC + WE_HIGH_CYC;
   localparam int T_A      = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
   localparam int T_B      = (READ_CYC > OE_GUARD_CYC) ? READ_CYC : OE_GUARD_CYC;
   localparam int TMR_MAX  = (T_A > T_B) ? T_A : T_B;
   localparam int TMR_W    = $clog2(TMR_MAX + 1);
   localparam int POLL_W   = $clog2(POLL_LIMIT + 1);
   localparam logic [PAGE_BITS:0] PAGE_FULL = {1'b1, {PAGE_BITS{1'b0}}};

   // elaboration checks on the device timing budget
   if (DATA_W != 8) begin : g_bad_width
      $error("data bus must be one byte");
   end
   if (ADDR_W < 16 || PAGE_BITS < 2 || PAGE_BITS >= ADDR_W) begin : g_bad_addr
      $error("address or page geometry out of range");
   end
   if (WE_LOW_CYC * CLK_NS < 100 || WE_HIGH_CYC * CLK_NS < 100) begin : g_bad_we
      $error("write strobe widths below 100 ns");
   end
   if (OE_GUARD_CYC * CLK_NS < 10) begin : g_bad_oe
      $error("output-enable guard below 10 ns");
   end
   if (BYTE_CYC * CLK_NS >= LOAD_WINDOW_NS) begin : g_bad_window
      $error("byte period exceeds the load window");
   end
   if (READ_CYC < 2 || POLL_LIMIT < 2) begin : g_bad_poll
      $error("read width or poll limit too small");
   end

   pw_state_e          state, st_n;
   logic [PG_W-1:0]    page_q;
   logic [PAGE_BITS:0] cnt_q;
   logic               unlock_q, mode_q, tmo_q;
   logic [STEP_W-1:0]  step, pre_len, total_m1;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  data_q;
   logic [POLL_W-1:0]  polls;
   logic               have_prev, prev6;
   logic               t_load, t_zero, poll_ready, in_prefix, last_step, poll_last;
   logic [TMR_W-1:0]   t_val;

   if (HAS_UNLOCK) begin : g_unlock
      assign pre_len = unlock_q ? STEP_W'(UNLOCK_LEN) : '0;
   end else begin : g_plain
      logic unused_unlock;
      assign unused_unlock = unlock_req ^ unlock_q;
      assign pre_len = '0;
   end

   assign in_prefix = (step < pre_len);
   assign buf_idx   = PAGE_BITS'(step - pre_len);
   assign total_m1  = {1'b0, cnt_q} + pre_len - 1'b1;
   assign last_step = (step == total_m1);
   assign poll_last = (polls == POLL_W'(POLL_LIMIT - 1));

   nvm_pw_timer #(.W(TMR_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_zero)
   );

   nvm_pw_poll_eval #(.DATA_W(DATA_W)) i_eval (
      .toggle_mode(mode_q), .sample(mem_din), .ref_msb(data_q[DATA_W-1]),
      .prev_b6(prev6), .have_prev(have_prev), .ready(poll_ready)
   );

   always_comb begin
      st_n   = state;
      t_load = 1'b0;
      t_val  = '0;
      case (state)
         ST_IDLE:
            if (start && byte_count != '0 && byte_count <= PAGE_FULL) st_n = ST_LOAD;
         ST_LOAD: begin
            st_n = ST_SETUP; t_load = 1'b1; t_val = TMR_W'(OE_GUARD_CYC - 1);
         end
         ST_SETUP:
            if (t_zero) begin
               st_n = ST_WLOW; t_load = 1'b1; t_val = TMR_W'(WE_LOW_CYC - 1);
            end
         ST_WLOW:
            if (t_zero) begin
               st_n = ST_WHIGH; t_load = 1'b1; t_val = TMR_W'(WE_HIGH_CYC - 1);
            end
         ST_WHIGH:
            if (t_zero) begin
               if (last_step) begin
                  st_n = ST_PGAP; t_load = 1'b1; t_val = TMR_W'(OE_GUARD_CYC - 1);
               end else begin
                  st_n = ST_LOAD;
               end
            end
         ST_PGAP:
            if (t_zero) begin
               st_n = ST_PREAD; t_load = 1'b1; t_val = TMR_W'(READ_CYC - 1);
            end
         ST_PREAD:
            if (t_zero) begin
               if (poll_ready || poll_last) st_n = ST_FIN;
               else begin
                  st_n = ST_PGAP; t_load = 1'b1; t_val = TMR_W'(OE_GUARD_CYC - 1);
               end
            end
         ST_FIN:  st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         page_q    <= '0;
         cnt_q     <= '0;
         unlock_q  <= 1'b0;
         mode_q    <= 1'b0;
         tmo_q     <= 1'b0;
         step      <= '0;
         addr_q    <= '0;
         data_q    <= '0;
         polls     <= '0;
         have_prev <= 1'b0;
         prev6     <= 1'b0;
      end else begin
         state <= st_n;
         case (state)
            ST_IDLE:
               if (st_n == ST_LOAD) begin
                  page_q    <= page_sel;
                  cnt_q     <= byte_count;
                  unlock_q  <= unlock_req;
                  mode_q    <= toggle_mode;
                  tmo_q     <= 1'b0;
                  step      <= '0;
                  polls     <= '0;
                  have_prev <= 1'b0;
               end
            ST_LOAD:
               if (in_prefix) begin
                  addr_q <= ADDR_W'(unlock_addr(step[1:0]));
                  data_q <= DATA_W'(unlock_data(step[1:0]));
               end else begin
                  addr_q <= {page_q, buf_idx};
                  data_q <= buf_data;
               end
            ST_WHIGH:
               if (t_zero && !last_step) step <= step + 1'b1;
            ST_PREAD:
               if (t_zero) begin
                  polls     <= polls + 1'b1;
                  prev6     <= mem_din[6];
                  have_prev <= 1'b1;
                  tmo_q     <= !poll_ready && poll_last;
               end
            default: ;
         endcase
      end
   end

   assign mem_addr  = addr_q;
   assign mem_dout  = data_q;
   assign mem_ce_n  = (state == ST_IDLE);
   assign mem_we_n  = (state != ST_WLOW);
   assign mem_oe_n  = (state != ST_PREAD);
   assign mem_drive = state inside {ST_LOAD, ST_SETUP, ST_WLOW, ST_WHIGH};
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_FIN);
   assign timed_out = done && tmo_q;
endmodule

// File: rtl/nvm_page_writer_chk.sv
module nvm_page_writer_chk #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int WE_LOW_CYC = 10,
   parameter int READ_CYC   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_ce_n,
   input logic              mem_drive,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dout,
   input logic              busy,
   input logic              done,
   input logic              timed_out
);
   logic [15:0] we_low_run, oe_low_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_low_run <= '0;
         oe_low_run <= '0;
      end else begin
         we_low_run <= !mem_we_n ? ((we_low_run == 16'hFFFF) ? we_low_run : we_low_run + 1'b1) : '0;
         oe_low_run <= !mem_oe_n ? ((oe_low_run == 16'hFFFF) ? oe_low_run : oe_low_run + 1'b1) : '0;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_drive));

   a_r4_we_min_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_run >= 16'(WE_LOW_CYC)));

   a_r4_bus_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

   a_r5_oe_high_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_drive && !mem_ce_n));

   a_r6_read_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_low_run >= 16'(READ_CYC)));

   a_r9_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      timed_out |-> done);

   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind nvm_page_writer nvm_page_writer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_LOW_CYC(WE_LOW_CYC), .READ_CYC(READ_CYC)
) i_chk (
   .clk(clk), .rst_n(rst_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
   .mem_ce_n(mem_ce_n), .mem_drive(mem_drive), .mem_addr(mem_addr),
   .mem_dout(mem_dout), .busy(busy), .done(done), .timed_out(timed_out)
);

// File: tb/test_nvm_page_writer.sv
module test_nvm_page_writer;
   localparam int LIMIT  = 12;
   localparam int GUARD  = 2;
   localparam int WLOW   = 10;
   localparam int WHIGH  = 10;
   localparam int RDC    = 16;
   localparam int WINDOW = 10000;

   // {unlock, toggle, page[8:0], count[7:0], busy_reads[7:0], seed[7:0]}
   localparam logic [34:0] VEC [0:6] = '{
      {1'b1, 1'b0, 9'h0A3, 8'd5,   8'd3,  8'h11},
      {1'b0, 1'b1, 9'h001, 8'd1,   8'd0,  8'h80},
      {1'b0, 1'b0, 9'h1FF, 8'd128, 8'd5,  8'h3C},
      {1'b1, 1'b1, 9'h055, 8'd3,   8'd4,  8'hC7},
      {1'b0, 1'b1, 9'h100, 8'd2,   8'd7,  8'h00},
      {1'b0, 1'b0, 9'h002, 8'd4,   8'd30, 8'h5A},
      {1'b1, 1'b1, 9'h0F0, 8'd6,   8'd40, 8'h21}
   };

   logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, unlock_req = 1'b0, toggle_mode = 1'b0;
   logic [8:0] page_sel = '0;
   logic [7:0] byte_count = '0, seed_r = '0, mem_din = '0;
   logic [6:0] buf_idx;
   logic [7:0] buf_data, mem_dout;
   logic [15:0] mem_addr;
   logic mem_drive, mem_ce_n, mem_oe_n, mem_we_n, busy, done, timed_out;

   int n_tests = 0, n_fail = 0, cyc = 0;
   int wr_n, rd_n, done_cnt, busy_reads, v_we, v_oe, v_rd;
   logic tmo_seen;
   logic [15:0] wr_addr [0:255];
   logic [7:0]  wr_data [0:255];
   logic [7:0]  last_wr;
   logic prev_we = 1'b1, prev_oe = 1'b1, had_fall = 1'b0;
   int we_low_run = 0, we_high_run = 0, oe_low_run = 0, oe_high_run = 0, since_fall = 0;

   always #5 clk = ~clk;

   function automatic logic [7:0] bufv(input int idx, input logic [7:0] s);
      return 8'(idx * 37) + s;
   endfunction

   assign buf_data = bufv(int'(buf_idx), seed_r);

   nvm_page_writer #(.POLL_LIMIT(LIMIT)) i_nvm_page_writer (
      .clk(clk), .rst_n(rst_n), .start(start), .unlock_req(unlock_req),
      .toggle_mode(toggle_mode), .page_sel(page_sel), .byte_count(byte_count),
      .buf_idx(buf_idx), .buf_data(buf_data), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_din(mem_din), .mem_drive(mem_drive), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .busy(busy), .done(done), .timed_out(timed_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bus monitor and device model, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_we_n && prev_we) begin
            if (oe_high_run < GUARD) v_oe++;
            if (wr_n > 0 && we_high_run < WHIGH) v_we++;
            if (had_fall && since_fall > WINDOW) v_we++;
            had_fall = 1'b1;
            since_fall = 0;
         end
         if (mem_we_n && !prev_we) begin
            if (we_low_run < WLOW) v_we++;
            if (wr_n < 256) begin
               wr_addr[wr_n] = mem_addr;
               wr_data[wr_n] = mem_dout;
            end
            last_wr = mem_dout;
            wr_n++;
         end
         if (!mem_oe_n && prev_oe) begin
            if (we_high_run < GUARD) v_oe++;
            rd_n++;
            if (rd_n <= busy_reads) mem_din = {~last_wr[7], rd_n[0], 6'b0};
            else                    mem_din = last_wr;
         end
         if (mem_oe_n && !prev_oe && oe_low_run < RDC) v_rd++;
         if (!mem_oe_n && (mem_drive || mem_ce_n)) v_rd++;
         if (!mem_we_n && !mem_oe_n) v_oe++;
         if (done) begin
            done_cnt++;
            tmo_seen = timed_out;
         end
      end
      we_low_run  = !mem_we_n ? we_low_run + 1 : 0;
      we_high_run =  mem_we_n ? we_high_run + 1 : 0;
      oe_low_run  = !mem_oe_n ? oe_low_run + 1 : 0;
      oe_high_run =  mem_oe_n ? oe_high_run + 1 : 0;
      since_fall++;
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   function automatic int exp_reads(input logic tgl, input int b, input logic [7:0] d);
      if (!tgl) return b + 1;
      for (int k = 2; k < b + 4; k++) begin
         logic bk, bp;
         bk = (k <= b) ? logic'(k % 2) : d[6];
         bp = (k - 1 <= b) ? logic'((k - 1) % 2) : d[6];
         if (bk == bp) return k;
      end
      return b + 2;
   endfunction

   task automatic run_op(input logic unl, input logic tgl, input logic [8:0] pg,
                         input logic [7:0] cnt, input logic [7:0] b, input logic [7:0] sd,
                         input bit poke);
      int g, pre, mism_pre, mism_body, er;
      logic [7:0] lastd;
      logic etmo;
      @(posedge clk);
      #1;
      wr_n = 0; rd_n = 0; done_cnt = 0; v_we = 0; v_oe = 0; v_rd = 0;
      tmo_seen = 1'b0; had_fall = 1'b0; busy_reads = int'(b); seed_r = sd;
      @(negedge clk);
      unlock_req = unl; toggle_mode = tgl; page_sel = pg; byte_count = cnt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
      g = 0;
      while (done_cnt == 0 && g < 60000) begin
         @(negedge clk);
         g++;
         if (poke && g == 40) begin
            page_sel = 9'h1AA; byte_count = 8'd7; start = 1'b1;
         end else begin
            start = 1'b0;
         end
      end
      repeat (3) @(negedge clk);
      pre = unl ? 3 : 0;
      lastd = bufv(int'(cnt) - 1, sd);
      er = exp_reads(tgl, int'(b), lastd);
      etmo = (er > LIMIT);
      if (etmo) er = LIMIT;
      mism_pre = 0;
      mism_body = 0;
      if (unl) begin
         if (wr_addr[0] != 16'h5555 || wr_data[0] != 8'hAA) mism_pre++;
         if (wr_addr[1] != 16'h2AAA || wr_data[1] != 8'h55) mism_pre++;
         if (wr_addr[2] != 16'h5555 || wr_data[2] != 8'hA0) mism_pre++;
         chk(mism_pre == 0, "R2 unlock prefix", mism_pre, 0);
      end
      chk(wr_n == pre + int'(cnt), "R2 R3 strobe count", wr_n, pre + int'(cnt));
      for (int j = 0; j < int'(cnt); j++) begin
         if (pre + j < 256 &&
             (wr_addr[pre + j] != {pg, j[6:0]} || wr_data[pre + j] != bufv(j, sd))) mism_body++;
      end
      chk(mism_body == 0, "R3 page bytes", mism_body, 0);
      chk(rd_n == er, tgl ? "R8 R9 poll reads" : "R7 R9 poll reads", rd_n, er);
      chk(tmo_seen == etmo, "R9 timeout flag", int'(tmo_seen), int'(etmo));
      chk(v_we == 0, "R4 strobe timing", v_we, 0);
      chk(v_oe == 0, "R5 output-enable guard", v_oe, 0);
      chk(v_rd == 0, "R6 poll read shape", v_rd, 0);
      chk(done_cnt == 1, "R11 single done", done_cnt, 1);
      chk(busy == 1'b0, "R11 idle after done", int'(busy), 0);
   endtask

   initial begin
      int idle_busy;
      // R1: quiet bus under reset
      repeat (4) @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
          int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
      chk(!mem_drive && !busy && !done, "R1 idle outputs in reset",
          int'({mem_drive, busy, done}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      for (int v = 0; v < 7; v++) begin
         run_op(VEC[v][34], VEC[v][33], VEC[v][32:24], VEC[v][23:16],
                VEC[v][15:8], VEC[v][7:0], 1'b0);
      end

      // R10: zero and oversized counts are ignored
      wr_n = 0;
      idle_busy = 0;
      @(negedge clk);
      byte_count = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) begin
         @(negedge clk);
         if (busy || !mem_ce_n) idle_busy++;
      end
      chk(idle_busy == 0 && wr_n == 0, "R10 zero count ignored", idle_busy + wr_n, 0);
      byte_count = 8'd129; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) begin
         @(negedge clk);
         if (busy || !mem_ce_n) idle_busy++;
      end
      chk(idle_busy == 0 && wr_n == 0, "R10 oversize count ignored", idle_busy + wr_n, 0);

      // R10: a start pulse mid-burst with another page changes nothing
      run_op(1'b0, 1'b0, 9'h033, 8'd3, 8'd2, 8'h44, 1'b1);
      idle_busy = 0;
      repeat (30) begin
         @(negedge clk);
         if (busy) idle_busy++;
      end
      chk(idle_busy == 0, "R10 start during busy ignored", idle_busy, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule